// File: doc/BRIEF.md
# Multi-level feature threshold encoder

This block turns a stream of signed fixed-point features into a packed vector of small level codes. A frame is a fixed number of features that arrive one per valid beat. The block compares each feature, as it arrives and with no scaling, against its own set of stored thresholds, and reduces it to one of several quantization levels. The level is written as a binary code into the feature's slot of an output register. When the last feature of a frame has been written, a one-cycle done pulse signals that the packed vector is complete and stable. The projection stage that follows can then consume it.

The thresholds are set in advance through a single-entry write port that takes a feature index, a slot number and a signed value. Software usually derives them from percentiles of training data. While a frame is being taken in, the write port is locked. A half-encoded frame therefore never mixes two sets of thresholds.

Top module: `feat_thr_encoder`

## Requirements
- R1: After reset, `code_vec_o` is all zeros, `done_o` is low, and every stored threshold is zero. With zero thresholds, a feature of 0 or above encodes to level 3 and a negative feature encodes to level 0.
- R2: The level of a feature is the number of its three stored thresholds that it is greater than or equal to. Both sides are compared as two's complement signed values. The level is 0 to 3.
- R3: The k-th accepted beat of a frame (k = 0 to N_FEAT-1) is feature k. Its level is written as a 2-bit unsigned code into `code_vec_o[2k+1:2k]`. A frame is exactly N_FEAT beats, and idle cycles between beats are allowed.
- R4: A feature exactly equal to one of its thresholds counts as reaching that threshold.
- R5: `done_o` is high for exactly one cycle: the cycle right after the clock edge that accepts the last beat of a frame. It is low at all other times.
- R6: `code_vec_o` changes only at an edge that accepts a beat. It holds its value between frames, including across threshold writes.
- R7: When `thr_we_i` is high, a rising edge stores `thr_data_i` as threshold slot `thr_slot_i` (0, 1 or 2) of feature `thr_feat_i`. A slot value of 3 stores nothing.
- R8: A threshold write is ignored in two cases: while a frame is partly received (at least one beat taken, the last not yet taken), and in any cycle where `feat_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_feat_i | input | IDX_W (7) | Feature index of the threshold write |
| thr_slot_i | input | SEL_W (2) | Threshold slot 0..2 of that feature |
| thr_data_i | input | FEAT_W (16) | Signed threshold value |
| feat_valid_i | input | 1 | Feature beat valid |
| feat_data_i | input | FEAT_W (16) | Signed raw feature |
| code_vec_o | output | N_FEAT*2 (256) | Packed level codes, feature k at bits 2k+1:2k |
| done_o | output | 1 | One-cycle pulse: the frame's vector is complete |

## Verification
The checker assumes that N_FEAT is above one, so that two frame ends can never fall on adjacent cycles. It also assumes that beats arrive only through `feat_valid_i`, with every frame fully delivered. The bench always sends whole frames and drives inputs only on falling edges. It places threshold writes both in legal idle cycles and inside frames, either beside a beat or between beats, so that the lock rule in R8 is tested on both sides.

// File: rtl/fte_pkg.sv
package fte_pkg;
  // index width that stays legal for a count of one
  function automatic int unsigned fte_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fte_thr_bank.sv
module fte_thr_bank import fte_pkg::*; #(
  parameter int unsigned N_FEAT = 128,
  parameter int unsigned FEAT_W = 16,
  parameter int unsigned N_THR  = 3,
  parameter int unsigned IDX_W  = fte_w(N_FEAT),
  parameter int unsigned SEL_W  = fte_w(N_THR)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [IDX_W-1:0]                   wr_idx_i,
  input  logic [SEL_W-1:0]                   wr_sel_i,
  input  logic [FEAT_W-1:0]                  wr_data_i,
  input  logic [IDX_W-1:0]                   rd_idx_i,
  output logic [N_THR-1:0][FEAT_W-1:0]       rd_thr_o,
  output logic [N_FEAT*N_THR*FEAT_W-1:0]     all_thr_o
);
  localparam int unsigned N_ENT = N_FEAT * N_THR;
  localparam int unsigned AW    = fte_w(N_ENT);

  logic [N_ENT-1:0][FEAT_W-1:0] thr_q;
  logic [AW-1:0]                wr_addr;
  logic [AW-1:0]                rd_base;
  logic                         wr_hit;

  assign wr_hit  = wr_en_i && (32'(wr_sel_i) < N_THR) && (32'(wr_idx_i) < N_FEAT);
  assign wr_addr = AW'(wr_idx_i) * AW'(N_THR) + AW'(wr_sel_i);
  assign rd_base = AW'(rd_idx_i) * AW'(N_THR);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             thr_q[e] <= '0;
      else if (wr_hit && wr_addr == AW'(e))    thr_q[e] <= wr_data_i;
    end
  end

  assign rd_thr_o  = thr_q[rd_base +: N_THR];
  assign all_thr_o = thr_q;
endmodule

// File: rtl/fte_quant.sv
module fte_quant #(
  parameter int unsigned FEAT_W = 16,
  parameter int unsigned N_THR  = 3,
  parameter int unsigned CODE_W = 2
) (
  input  logic [FEAT_W-1:0]            feat_i,
  input  logic [N_THR-1:0][FEAT_W-1:0] thr_i,
  output logic [CODE_W-1:0]            code_o
);
  logic [N_THR-1:0] ge;

  for (genvar k = 0; k < N_THR; k++) begin : g_cmp
    assign ge[k] = $signed(feat_i) >= $signed(thr_i[k]);
  end

  // level = thresholds reached; order of thresholds does not matter
  always_comb begin
    code_o = '0;
    for (int k = 0; k < N_THR; k++) code_o = code_o + CODE_W'(ge[k]);
  end
endmodule

// File: rtl/fte_seq.sv
module fte_seq import fte_pkg::*; #(
  parameter int unsigned N_FEAT = 128,
  parameter int unsigned IDX_W  = fte_w(N_FEAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FEAT - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             done_q;
  logic             last;

  assign last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= beat_i && last;
      if (beat_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign idx_o  = cnt_q;
  assign busy_o = (cnt_q != '0) || beat_i;
  assign done_o = done_q;
endmodule

// File: rtl/feat_thr_encoder.sv
module feat_thr_encoder import fte_pkg::*; #(
  parameter  int unsigned N_FEAT = 128,
  parameter  int unsigned FEAT_W = 16,
  parameter  int unsigned N_LVL  = 4,
  localparam int unsigned N_THR  = N_LVL - 1,
  localparam int unsigned CODE_W = fte_w(N_LVL),
  localparam int unsigned IDX_W  = fte_w(N_FEAT),
  localparam int unsigned SEL_W  = fte_w(N_THR),
  localparam int unsigned VEC_W  = N_FEAT * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_we_i,
  input  logic [IDX_W-1:0]  thr_feat_i,
  input  logic [SEL_W-1:0]  thr_slot_i,
  input  logic [FEAT_W-1:0] thr_data_i,
  input  logic              feat_valid_i,
  input  logic [FEAT_W-1:0] feat_data_i,
  output logic [VEC_W-1:0]  code_vec_o,
  output logic              done_o
);
  logic [IDX_W-1:0]                idx;
  logic                            wr_busy;
  logic [N_THR-1:0][FEAT_W-1:0]    cur_thr;
  logic [N_FEAT*N_THR*FEAT_W-1:0]  thr_all;
  logic [CODE_W-1:0]               code;
  logic [VEC_W-1:0]                vec_q;

  fte_seq #(.N_FEAT(N_FEAT), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .beat_i (feat_valid_i),
    .idx_o  (idx),
    .busy_o (wr_busy),
    .done_o (done_o)
  );

  fte_thr_bank #(
    .N_FEAT(N_FEAT), .FEAT_W(FEAT_W), .N_THR(N_THR), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i   (thr_we_i && !wr_busy),
    .wr_idx_i  (thr_feat_i),
    .wr_sel_i  (thr_slot_i),
    .wr_data_i (thr_data_i),
    .rd_idx_i  (idx),
    .rd_thr_o  (cur_thr),
    .all_thr_o (thr_all)
  );

  fte_quant #(.FEAT_W(FEAT_W), .N_THR(N_THR), .CODE_W(CODE_W)) u_quant (
    .feat_i (feat_data_i),
    .thr_i  (cur_thr),
    .code_o (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           vec_q <= '0;
    else if (feat_valid_i) vec_q[idx*CODE_W +: CODE_W] <= code;
  end

  assign code_vec_o = vec_q;
endmodule

// File: rtl/fte_chk.sv
module fte_chk #(
  parameter int unsigned N_FEAT = 128,
  parameter int unsigned FEAT_W = 16,
  parameter int unsigned N_LVL  = 4,
  parameter int unsigned VEC_W  = N_FEAT * $clog2(N_LVL),
  parameter int unsigned TW     = N_FEAT * (N_LVL - 1) * FEAT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             feat_valid_i,
  input logic             thr_we_i,
  input logic             done_o,
  input logic [VEC_W-1:0] code_vec_o,
  input logic             busy_i,
  input logic [TW-1:0]    thr_all_i
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(feat_valid_i)); // R5
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !feat_valid_i |=> $stable(code_vec_o)); // R6
  AST_THR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_i && busy_i) |=> $stable(thr_all_i)); // R8
  AST_THR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_we_i |=> $stable(thr_all_i)); // R7
endmodule

bind feat_thr_encoder fte_chk #(
  .N_FEAT(N_FEAT), .FEAT_W(FEAT_W), .N_LVL(N_LVL)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .feat_valid_i (feat_valid_i),
  .thr_we_i     (thr_we_i),
  .done_o       (done_o),
  .code_vec_o   (code_vec_o),
  .busy_i       (wr_busy),
  .thr_all_i    (thr_all)
);

// File: tb/feat_thr_encoder_bench.sv
module feat_thr_encoder_bench;
  localparam int NF = 128;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          thr_we_i = 1'b0;
  logic [6:0]    thr_feat_i = '0;
  logic [1:0]    thr_slot_i = '0;
  logic [FW-1:0] thr_data_i = '0;
  logic          feat_valid_i = 1'b0;
  logic [FW-1:0] feat_data_i = '0;
  logic [2*NF-1:0] code_vec_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic signed [FW-1:0] m_thr [NF][3];
  logic signed [FW-1:0] fv [NF];

  always #4 clk = ~clk;

  feat_thr_encoder u_feat_thr_encoder (
    .clk_i(clk), .rst_ni, .thr_we_i, .thr_feat_i, .thr_slot_i, .thr_data_i,
    .feat_valid_i, .feat_data_i, .code_vec_o, .done_o
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_lvl(input int i);
    int l = 0;
    for (int s = 0; s < 3; s++) if (fv[i] >= m_thr[i][s]) l++;
    return l;
  endfunction

  task automatic wr_thr(input int i, input int s, input int d, input bit legal);
    @(negedge clk);
    thr_we_i = 1'b1; thr_feat_i = 7'(i); thr_slot_i = 2'(s); thr_data_i = FW'(d);
    @(negedge clk);
    thr_we_i = 1'b0;
    if (legal && s < 3) m_thr[i][s] = FW'(d);
  endtask

  // compares the full vector against the model, one check
  task automatic check_vec(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < NF; i++)
      if (int'(code_vec_o[2*i +: 2]) != exp_lvl(i)) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(req, 1'b1, 0, 0);
    else check(req, 1'b0, code_vec_o[2*first +: 2], exp_lvl(first));
  endtask

  // gap: idle cycle before some beats; lock_at: index at which illegal writes are tried
  task automatic send_frame(input bit gap, input int lock_at, input string req);
    int early = 0;
    for (int i = 0; i < NF; i++) begin
      if (gap && (i % 7 == 3)) begin
        @(negedge clk);
        feat_valid_i = 1'b0;
        if (done_o) early++;
      end
      @(negedge clk);
      if (done_o) early++;
      if (i == lock_at) begin
        thr_we_i = 1'b1; thr_feat_i = 7'(1); thr_slot_i = 2'd0; thr_data_i = 16'sh7fff;
      end else begin
        thr_we_i = 1'b0;
      end
      feat_valid_i = 1'b1;
      feat_data_i  = fv[i];
    end
    @(negedge clk);
    feat_valid_i = 1'b0;
    thr_we_i = 1'b0;
    check({req, " R5 no early done"}, early == 0, early, 0);
    check({req, " R5 done after last"}, done_o == 1'b1, done_o, 1);
    check_vec({req, " R2 R3 vector"});
    @(negedge clk);
    check({req, " R5 done one cycle"}, done_o == 1'b0, done_o, 0);
  endtask

  task automatic t_reset;
    check("R1 vec zero", code_vec_o == '0, code_vec_o[63:0], 0);
    check("R1 done low", done_o == 1'b0, done_o, 0);
    for (int i = 0; i < NF; i++) begin
      for (int s = 0; s < 3; s++) m_thr[i][s] = '0;
      fv[i] = (i % 2 == 1) ? -16'sd1 : ((i % 4 == 0) ? 16'sd0 : 16'sd5);
    end
    send_frame(1'b0, -1, "R1 zero thresholds");
  endtask

  task automatic t_program;
    for (int i = 0; i < NF; i++) begin
      wr_thr(i, 0, -1000 + 4*i, 1'b1);
      wr_thr(i, 1, 4*i, 1'b1);
      wr_thr(i, 2, 1000 + 4*i, 1'b1);
    end
    wr_thr(5, 3, 12345, 1'b1); // R7 slot 3 stores nothing
  endtask

  task automatic t_levels;
    for (int i = 0; i < NF; i++)
      case (i % 5)
        0: fv[i] = m_thr[i][0] - 1;
        1: fv[i] = m_thr[i][0];      // R4 equality
        2: fv[i] = m_thr[i][1];      // R4
        3: fv[i] = m_thr[i][2];      // R4
        default: fv[i] = m_thr[i][2] - 1;
      endcase
    send_frame(1'b0, -1, "R4 R7 levels");
  endtask

  task automatic t_extremes;
    for (int i = 0; i < NF; i++) fv[i] = (i % 2 == 0) ? 16'sh8000 : 16'sh7fff;
    send_frame(1'b1, -1, "R2 R3 extremes gaps");
  endtask

  task automatic t_hold;
    logic [2*NF-1:0] snap;
    snap = code_vec_o;
    repeat (5) @(negedge clk);
    check("R6 vec holds idle", code_vec_o == snap, code_vec_o[63:0], snap[63:0]);
    wr_thr(0, 2, -5, 1'b1);
    @(negedge clk);
    check("R6 vec holds over write", code_vec_o == snap, code_vec_o[63:0], snap[63:0]);
  endtask

  task automatic t_lock;
    for (int i = 0; i < NF; i++) fv[i] = m_thr[i][0] + 2;
    // write beside a beat (index 60), not recorded in the model
    send_frame(1'b0, 60, "R8 frame with blocked write");
    for (int i = 0; i < NF; i++) fv[i] = 16'(i - 40);
    // partial frame, then an idle-cycle write that must be ignored
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      feat_valid_i = 1'b1; feat_data_i = fv[i];
    end
    @(negedge clk);
    feat_valid_i = 1'b0;
    thr_we_i = 1'b1; thr_feat_i = 7'd100; thr_slot_i = 2'd1; thr_data_i = 16'sh7fff;
    @(negedge clk);
    thr_we_i = 1'b0;
    for (int i = 30; i < NF; i++) begin
      feat_valid_i = 1'b1; feat_data_i = fv[i];
      @(negedge clk);
    end
    feat_valid_i = 1'b0;
    check("R5 done after split frame", done_o == 1'b1, done_o, 1);
    check_vec("R8 thresholds unchanged mid frame");
    @(negedge clk);
    fv[1] = m_thr[1][0]; fv[100] = m_thr[100][1];
    send_frame(1'b0, -1, "R8 old thresholds still used");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_levels();
    t_extremes();
    t_hold();
    t_lock();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule